// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block looks at a parameterised set of interrupt sources on behalf of a parameterised number of processors. For each processor it finds, among the sources that are enabled and pending for that processor, the one with the most urgent priority. Priority values are 8 bits wide, and a smaller value is more urgent. The block then reports that source's identifier and decides whether to raise the processor's interrupt request.

A found source is published as that processor's highest-pending identifier when its priority passes the processor's priority mask. The request line is raised only when that priority also strictly beats the priority the processor is already running. A group of low-numbered sources is banked: each processor has its own priority for them. All higher sources share one priority across processors. The search runs in a combinational reduction tree, and both outputs are registered once per clock. Register access, acknowledge and end-of-interrupt handling live in neighbouring blocks.

Top module: `hpsel_top`

## Requirements
- R1: While `rst_ni` is low, every `irq_o` bit is 0 and every field of `hp_id_o` is 1023.
- R2: Source s is a candidate for processor c only when `src_en_i[s]` is 1 and `pend_i[c*NUM_SRC+s]` is 1. No other source is ever reported for c.
- R3: Among the candidates, the one with the numerically smallest priority is selected.
- R4: When several candidates share the smallest priority, the lowest-numbered source is selected.
- R5: Sources below NUM_BANKED take processor c's priority from `prio_bank_i[(c*NUM_BANKED+s)*8 +: 8]`. Sources at or above NUM_BANKED take theirs from `prio_shared_i[(s-NUM_BANKED)*8 +: 8]` for every processor.
- R6: The selected identifier appears in `hp_id_o[c*10 +: 10]` only when its priority is less than or equal to `prio_mask_i[c*8 +: 8]`. Otherwise the field is 1023 and `irq_o[c]` is 0.
- R7: `irq_o[c]` is 1 only when an identifier is published and its priority, zero-extended to 9 bits, is strictly less than `run_prio_i[c*9 +: 9]`. The value 256 means nothing is running.
- R8: When `dist_en_i` is 0, or when `cpu_en_i[c]` is 0, `irq_o[c]` is 0 and the field of processor c reads 1023.
- R9: Both outputs reflect the inputs sampled at the previous rising clock edge. Exactly one register stage lies between inputs and outputs.
- R10: With no candidate for processor c, its field reads 1023 and `irq_o[c]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dist_en_i | input | 1 | Global distribution enable |
| cpu_en_i | input | NUM_CPU | Per-processor interface enable |
| src_en_i | input | NUM_SRC | Per-source enable |
| pend_i | input | NUM_CPU*NUM_SRC | Pending bits, processor c source s at bit c*NUM_SRC+s |
| prio_bank_i | input | NUM_CPU*NUM_BANKED*8 | Banked priorities per processor |
| prio_shared_i | input | (NUM_SRC-NUM_BANKED)*8 | Shared priorities of the upper sources |
| prio_mask_i | input | NUM_CPU*8 | Per-processor priority mask |
| run_prio_i | input | NUM_CPU*9 | Per-processor running priority, 256 = idle |
| irq_o | output | NUM_CPU | Per-processor interrupt request |
| hp_id_o | output | NUM_CPU*10 | Per-processor highest-pending identifier, 1023 = none |

## Verification
The assertions take for granted that NUM_SRC stays below 1023, so that a real identifier can never collide with the empty value. They also rely on inputs changing only between clock edges, so that the values sampled one edge earlier are the ones that produced the registered outputs. The stimulus changes every input only on the falling edge, and it never sets a running priority above 256. Its sweeps cover every source position, the exact boundaries of the mask and of the running priority, and a long run of mixed random patterns.

// File: rtl/hpsel_pkg.sv
package hpsel_pkg;
    localparam int PRIO_W = 8;
    localparam int RUN_W  = PRIO_W + 1;
    localparam int ID_W   = 10;
    localparam logic [ID_W-1:0]  NONE_ID  = 10'd1023;
    localparam logic [RUN_W-1:0] IDLE_RUN = 9'h100;

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   id;
    } cand_t;

    // Left operand always carries the lower identifiers; it wins ties.
    function automatic cand_t pick_better(cand_t lo, cand_t hi);
        if (lo.valid && (!hi.valid || lo.prio <= hi.prio))
            return lo;
        return hi;
    endfunction
endpackage

// File: rtl/hpsel_prio_gather.sv
module hpsel_prio_gather
    import hpsel_pkg::*;
#(
    parameter int NUM_SRC    = 64,
    parameter int NUM_CPU    = 2,
    parameter int NUM_BANKED = 32,
    parameter int CPU        = 0
) (
    input  logic [NUM_CPU*NUM_BANKED*PRIO_W-1:0]      prio_bank_i,
    input  logic [(NUM_SRC-NUM_BANKED)*PRIO_W-1:0]    prio_shared_i,
    output logic [NUM_SRC*PRIO_W-1:0]                 prio_o
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        if (s < NUM_BANKED) begin : g_bank
            assign prio_o[s*PRIO_W +: PRIO_W] =
                prio_bank_i[(CPU*NUM_BANKED+s)*PRIO_W +: PRIO_W];
        end else begin : g_shared
            assign prio_o[s*PRIO_W +: PRIO_W] =
                prio_shared_i[(s-NUM_BANKED)*PRIO_W +: PRIO_W];
        end
    end
endmodule

// File: rtl/hpsel_tree.sv
module hpsel_tree
    import hpsel_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0]        cand_vld_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    output cand_t                     best_o
);
    localparam int DEPTH  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 0;
    localparam int LEAVES = 1 << DEPTH;

    for (genvar l = 0; l <= DEPTH; l++) begin : g_lvl
        localparam int N = LEAVES >> l;
        cand_t node [N];
        for (genvar k = 0; k < N; k++) begin : g_node
            if (l == 0) begin : g_leaf
                if (k < NUM_SRC) begin : g_real
                    assign node[k] = '{valid: cand_vld_i[k],
                                       prio:  prio_i[k*PRIO_W +: PRIO_W],
                                       id:    ID_W'(k)};
                end else begin : g_pad
                    assign node[k] = '0;
                end
            end else begin : g_merge
                assign node[k] = pick_better(g_lvl[l-1].node[2*k],
                                             g_lvl[l-1].node[2*k+1]);
            end
        end
    end

    assign best_o = g_lvl[DEPTH].node[0];
endmodule

// File: rtl/hpsel_gate.sv
module hpsel_gate
    import hpsel_pkg::*;
(
    input  cand_t              best_i,
    input  logic               dist_en_i,
    input  logic               cpu_en_i,
    input  logic [PRIO_W-1:0]  mask_i,
    input  logic [RUN_W-1:0]   run_i,
    output logic [ID_W-1:0]    id_o,
    output logic               irq_o
);
    logic publish;

    always_comb begin
        publish = dist_en_i && cpu_en_i && best_i.valid && (best_i.prio <= mask_i);
        id_o    = publish ? best_i.id : NONE_ID;
        irq_o   = publish && ({1'b0, best_i.prio} < run_i);
    end
endmodule

// File: rtl/hpsel_top.sv
module hpsel_top
    import hpsel_pkg::*;
#(
    parameter int NUM_SRC    = 64,
    parameter int NUM_CPU    = 2,
    parameter int NUM_BANKED = 32
) (
    input  logic                                   clk_i,
    input  logic                                   rst_ni,
    input  logic                                   dist_en_i,
    input  logic [NUM_CPU-1:0]                     cpu_en_i,
    input  logic [NUM_SRC-1:0]                     src_en_i,
    input  logic [NUM_CPU*NUM_SRC-1:0]             pend_i,
    input  logic [NUM_CPU*NUM_BANKED*PRIO_W-1:0]   prio_bank_i,
    input  logic [(NUM_SRC-NUM_BANKED)*PRIO_W-1:0] prio_shared_i,
    input  logic [NUM_CPU*PRIO_W-1:0]              prio_mask_i,
    input  logic [NUM_CPU*RUN_W-1:0]               run_prio_i,
    output logic [NUM_CPU-1:0]                     irq_o,
    output logic [NUM_CPU*ID_W-1:0]                hp_id_o
);
    typedef struct packed {
        logic [NUM_CPU-1:0]           irq;
        logic [NUM_CPU-1:0][ID_W-1:0] id;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_CPU-1:0][NUM_SRC-1:0]        cand_vld;
    logic [NUM_CPU-1:0][NUM_SRC*PRIO_W-1:0] prio_all;
    cand_t                                  best [NUM_CPU];
    logic [NUM_CPU-1:0][ID_W-1:0]           id_nx;
    logic [NUM_CPU-1:0]                     irq_nx;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        assign cand_vld[c] = src_en_i & pend_i[c*NUM_SRC +: NUM_SRC];

        hpsel_prio_gather #(
            .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU),
            .NUM_BANKED(NUM_BANKED), .CPU(c)
        ) gather_i (
            .prio_bank_i  (prio_bank_i),
            .prio_shared_i(prio_shared_i),
            .prio_o       (prio_all[c])
        );

        hpsel_tree #(.NUM_SRC(NUM_SRC)) tree_i (
            .cand_vld_i(cand_vld[c]),
            .prio_i    (prio_all[c]),
            .best_o    (best[c])
        );

        hpsel_gate gate_i (
            .best_i   (best[c]),
            .dist_en_i(dist_en_i),
            .cpu_en_i (cpu_en_i[c]),
            .mask_i   (prio_mask_i[c*PRIO_W +: PRIO_W]),
            .run_i    (run_prio_i[c*RUN_W +: RUN_W]),
            .id_o     (id_nx[c]),
            .irq_o    (irq_nx[c])
        );

        assign irq_o[c]                 = state_q.irq[c];
        assign hp_id_o[c*ID_W +: ID_W]  = state_q.id[c];

        // R7
        irq_has_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o[c] |-> (hp_id_o[c*ID_W +: ID_W] != NONE_ID));

        // R8
        gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!dist_en_i || !cpu_en_i[c]) |=>
                (!irq_o[c] && hp_id_o[c*ID_W +: ID_W] == NONE_ID));

        // R6
        mask_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (hp_id_o[c*ID_W +: ID_W] != NONE_ID) |->
                ($past(best[c].prio) <= $past(prio_mask_i[c*PRIO_W +: PRIO_W])));

        // R3 R4
        always @(posedge clk_i) begin
            if (rst_ni) begin
                for (int s = 0; s < NUM_SRC; s++) begin
                    if (cand_vld[c][s]) begin
                        best_min_chk: assert (best[c].valid &&
                            (best[c].prio < prio_all[c][s*PRIO_W +: PRIO_W] ||
                             (best[c].prio == prio_all[c][s*PRIO_W +: PRIO_W] &&
                              best[c].id <= ID_W'(s))));
                    end
                end
            end
        end
    end

    always_comb begin
        state_d = state_q;
        for (int c = 0; c < NUM_CPU; c++) begin
            state_d.irq[c] = irq_nx[c];
            state_d.id[c]  = id_nx[c];
        end
    end

    // R1 R9
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.irq <= '0;
            for (int c = 0; c < NUM_CPU; c++) state_q.id[c] <= NONE_ID;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: tb/hpsel_top_tb_top.sv
`timescale 1ns/1ps
module hpsel_top_tb_top;
    localparam int NS = 64;
    localparam int NC = 2;
    localparam int NB = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic                     dist_en_i;
    logic [NC-1:0]            cpu_en_i;
    logic [NS-1:0]            src_en_i;
    logic [NC*NS-1:0]         pend_i;
    logic [NC*NB*8-1:0]       prio_bank_i;
    logic [(NS-NB)*8-1:0]     prio_shared_i;
    logic [NC*8-1:0]          prio_mask_i;
    logic [NC*9-1:0]          run_prio_i;
    logic [NC-1:0]            irq_o;
    logic [NC*10-1:0]         hp_id_o;

    hpsel_top #(.NUM_SRC(NS), .NUM_CPU(NC), .NUM_BANKED(NB)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .dist_en_i(dist_en_i), .cpu_en_i(cpu_en_i),
        .src_en_i(src_en_i), .pend_i(pend_i), .prio_bank_i(prio_bank_i),
        .prio_shared_i(prio_shared_i), .prio_mask_i(prio_mask_i),
        .run_prio_i(run_prio_i), .irq_o(irq_o), .hp_id_o(hp_id_o)
    );

    // Bench-side model state
    bit       m_dist;
    bit       m_cen  [NC];
    bit       m_en   [NS];
    bit       m_pend [NC][NS];
    int       m_pb   [NC][NB];
    int       m_ps   [NS-NB];
    int       m_mask [NC];
    int       m_run  [NC];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    task automatic drive();
        dist_en_i = m_dist;
        for (int c = 0; c < NC; c++) begin
            cpu_en_i[c] = m_cen[c];
            prio_mask_i[c*8 +: 8] = m_mask[c][7:0];
            run_prio_i[c*9 +: 9]  = m_run[c][8:0];
            for (int s = 0; s < NS; s++) pend_i[c*NS+s] = m_pend[c][s];
            for (int s = 0; s < NB; s++) prio_bank_i[(c*NB+s)*8 +: 8] = m_pb[c][s][7:0];
        end
        for (int s = 0; s < NS; s++) src_en_i[s] = m_en[s];
        for (int s = 0; s < NS-NB; s++) prio_shared_i[s*8 +: 8] = m_ps[s][7:0];
    endtask

    task automatic clear_all();
        m_dist = 1'b1;
        for (int c = 0; c < NC; c++) begin
            m_cen[c] = 1'b1; m_mask[c] = 255; m_run[c] = 256;
            for (int s = 0; s < NS; s++) m_pend[c][s] = 1'b0;
            for (int s = 0; s < NB; s++) m_pb[c][s] = 128;
        end
        for (int s = 0; s < NS; s++) m_en[s] = 1'b0;
        for (int s = 0; s < NS-NB; s++) m_ps[s] = 128;
    endtask

    function automatic void model(int c, output int id, output bit irq);
        int bp = 256;
        int bi = 1023;
        id = 1023; irq = 1'b0;
        if (!m_dist || !m_cen[c]) return;
        for (int s = 0; s < NS; s++) begin
            if (m_en[s] && m_pend[c][s]) begin
                int p = (s < NB) ? m_pb[c][s] : m_ps[s-NB];
                if (p < bp) begin bp = p; bi = s; end
            end
        end
        if (bp <= m_mask[c]) begin
            id  = bi;
            irq = (bp < m_run[c]);
        end
    endfunction

    task automatic check_now(string tag);
        for (int c = 0; c < NC; c++) begin
            int id_e; bit irq_e;
            model(c, id_e, irq_e);
            n_checks++;
            if (int'(hp_id_o[c*10 +: 10]) != id_e) begin
                n_fail++;
                $display("FAIL %s cpu%0d id: actual %0d expected %0d", tag, c, hp_id_o[c*10 +: 10], id_e);
            end
            n_checks++;
            if (irq_o[c] != irq_e) begin
                n_fail++;
                $display("FAIL %s cpu%0d irq: actual %0b expected %0b", tag, c, irq_o[c], irq_e);
            end
        end
    endtask

    task automatic apply(string tag);
        @(negedge clk);
        drive();
        @(posedge clk);
        @(negedge clk);
        check_now(tag);
    endtask

    initial begin
        int id_e; bit irq_e; int old_id;
        // R1: inputs that would fire, held under reset
        clear_all();
        m_en[3] = 1'b1; m_pend[0][3] = 1'b1; m_pend[1][3] = 1'b1;
        drive();
        repeat (3) @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            n_checks++;
            if (irq_o[c] !== 1'b0 || hp_id_o[c*10 +: 10] !== 10'd1023) begin
                n_fail++;
                $display("FAIL R1 cpu%0d: actual irq %0b id %0d expected irq 0 id 1023", c, irq_o[c], hp_id_o[c*10 +: 10]);
            end
        end
        @(negedge clk) rst_n = 1'b1;

        // R10: nothing pending
        clear_all(); apply("R10");

        // R2: single source per position, only on one processor
        for (int s = 0; s < NS; s++) begin
            clear_all(); m_en[s] = 1'b1; m_pend[s%2][s] = 1'b1; apply("R2");
            clear_all(); m_pend[0][s] = 1'b1; m_pend[1][s] = 1'b1; apply("R2");
        end

        // R3: each position in turn is the single most urgent source
        for (int k = 0; k < NS; k++) begin
            clear_all();
            for (int s = 0; s < NS; s++) begin m_en[s] = 1'b1; m_pend[0][s] = 1'b1; m_pend[1][s] = 1'b1; end
            for (int s = 0; s < NB; s++) begin m_pb[0][s] = 64 + s; m_pb[1][s] = 200 - s; end
            for (int s = 0; s < NS-NB; s++) m_ps[s] = 100 + s;
            if (k < NB) begin m_pb[0][k] = 1; m_pb[1][k] = 1; end
            else m_ps[k-NB] = 1;
            apply("R3");
        end

        // R4: ties resolve to the lowest identifier
        for (int lo = 0; lo < NS; lo += 7) begin
            clear_all();
            for (int s = lo; s < NS; s++) begin m_en[s] = 1'b1; m_pend[0][s] = 1'b1; m_pend[1][s] = 1'b1; end
            apply("R4");
        end

        // R5: banked versus shared priorities
        clear_all();
        m_en[5] = 1'b1; m_en[40] = 1'b1;
        m_pend[0][5] = 1'b1; m_pend[1][5] = 1'b1; m_pend[0][40] = 1'b1; m_pend[1][40] = 1'b1;
        m_pb[0][5] = 16; m_pb[1][5] = 144; m_ps[40-NB] = 80;
        apply("R5");
        m_ps[40-NB] = 8; apply("R5");
        m_pb[1][5] = 4; apply("R5");

        // R6: mask boundary around priority 96
        for (int mk = 94; mk <= 98; mk++) begin
            clear_all(); m_en[50] = 1'b1; m_pend[0][50] = 1'b1; m_pend[1][50] = 1'b1;
            m_ps[50-NB] = 96; m_mask[0] = mk; m_mask[1] = 255 - mk; apply("R6");
        end

        // R7: running priority boundary
        for (int rp = 94; rp <= 98; rp++) begin
            clear_all(); m_en[9] = 1'b1; m_pend[0][9] = 1'b1; m_pend[1][9] = 1'b1;
            m_pb[0][9] = 96; m_pb[1][9] = 96; m_run[0] = rp; m_run[1] = 256; apply("R7");
        end
        clear_all(); m_en[0] = 1'b1; m_pend[0][0] = 1'b1; m_pb[0][0] = 0; m_run[0] = 0; apply("R7");

        // R8: global and per-processor disable
        clear_all(); m_en[12] = 1'b1; m_pend[0][12] = 1'b1; m_pend[1][12] = 1'b1;
        m_dist = 1'b0; apply("R8");
        m_dist = 1'b1; m_cen[0] = 1'b0; apply("R8");
        m_cen[0] = 1'b1; m_cen[1] = 1'b0; apply("R8");

        // R9: one register stage of latency
        clear_all(); m_en[20] = 1'b1; m_pend[0][20] = 1'b1; apply("R9");
        old_id = hp_id_o[9:0];
        m_en[33] = 1'b1; m_pend[0][33] = 1'b1; m_ps[33-NB] = 2;
        @(negedge clk); drive(); #1;
        n_checks++;
        if (int'(hp_id_o[9:0]) != old_id) begin
            n_fail++; $display("FAIL R9 early change: actual %0d expected %0d", hp_id_o[9:0], old_id);
        end
        @(posedge clk); @(negedge clk);
        model(0, id_e, irq_e);
        n_checks++;
        if (int'(hp_id_o[9:0]) != id_e) begin
            n_fail++; $display("FAIL R9 after edge: actual %0d expected %0d", hp_id_o[9:0], id_e);
        end

        // R2 R3 R4 R5 R6 R7 R8: mixed random patterns
        for (int it = 0; it < 600; it++) begin
            m_dist = ($urandom % 16) != 0;
            for (int c = 0; c < NC; c++) begin
                m_cen[c]  = ($urandom % 16) != 0;
                m_mask[c] = $urandom % 256;
                m_run[c]  = ($urandom % 4 == 0) ? 256 : $urandom % 256;
                for (int s = 0; s < NS; s++) m_pend[c][s] = ($urandom % 6) == 0;
                for (int s = 0; s < NB; s++) m_pb[c][s] = $urandom % 32 * 8;
            end
            for (int s = 0; s < NS; s++) m_en[s] = ($urandom % 3) != 0;
            for (int s = 0; s < NS-NB; s++) m_ps[s] = $urandom % 32 * 8;
            apply("R3-mix");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule